// File: doc/BRIEF.md
# Single Precision Result Packer

The packer takes a floating-point result in an unpacked form (a class code, a sign, an unbiased two's-complement exponent and a left-aligned mantissa with extra low-order bits and a sticky flag) and turns it into a 32-bit IEEE 754 single-precision word. A rounding-mode input chooses one of four directions. The block also reports four flags: underflow, overflow, inexact and operand error. It sits at the tail of an arithmetic pipeline. A result enters with a valid strobe, and the packed word and flags appear on registered outputs one clock later.

Numeric values go through a common path. The biased exponent is formed first. A value whose biased exponent is zero or below is denormalised: its mantissa is shifted right by the deficit, and every bit shifted out joins the sticky bit. The kept 24 bits are then rounded. A carry out of the rounder either promotes a subnormal to the smallest normal or raises the exponent of a normal by one. A result that lands at exponent 255 or higher overflows. Depending on the mode and the sign, an overflow becomes infinity or the largest finite magnitude. NaN, infinity and zero inputs bypass the rounder.

Top module: `sp_packer`

## Requirements
- R1: `out_valid` rises in the clock cycle after an `in_valid` cycle and is low after a cycle without `in_valid`. Reset (`rst_n` low, asynchronous) clears `out_valid`, `out_word` and all four flags.
- R2: `in_class` is encoded as 0 zero, 1 finite number, 2 infinity, 3 NaN. A zero packs to the sign in bit 31 with all other bits 0. An infinity packs to the sign, exponent field (bits 30:23) 255 and fraction 0. Both leave all flags clear.
- R3: A NaN packs to the sign, exponent field 255 and fraction `in_mant[MW-2:MW-24]` (the 23 bits below the top bit, where the quiet bit already sits). All flags are clear.
- R4: `in_rmode` is encoded as 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity. Bit `MW-25` is the guard bit, bit `MW-26` is the round bit, and all lower bits together with `in_sticky` form the sticky bit. `out_inexact` is set exactly when any of these is nonzero.
- R5: When rounding a normal value carries its mantissa to 2.0, the exponent field is one higher than the biased exponent and the fraction is 0.
- R6: If `in_exp + 127 <= 0`, the result is subnormal. `out_unf` is set, the mantissa including its top bit is shifted right by `1 - (in_exp + 127)` before rounding, and the exponent field is 0.
- R7: If rounding a subnormal carries into bit 23, the result is the smallest normal: exponent field 1, fraction 0, and `out_unf` is still set.
- R8: If the final exponent is 255 or more, `out_ovf`, `out_inexact` and `out_operr` are all set.
- R9: On overflow, nearest-even gives infinity and toward-zero gives the largest finite value (exponent field 254, fraction all ones). Toward plus infinity gives infinity only for positive values, and toward minus infinity only for negative values. The sign is kept in every case.
- R10: A finite number must have `in_mant[MW-1]` set. For an exact normal result the fraction equals `in_mant[MW-2:MW-24]` and the exponent field equals `in_exp + 127`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input result present this cycle |
| in_class | input | 2 | Value class (R2 encoding) |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | EW | Unbiased exponent, two's complement |
| in_mant | input | MW | Mantissa, hidden bit at MW-1 |
| in_sticky | input | 1 | OR of bits already discarded upstream |
| in_rmode | input | 2 | Rounding mode (R4 encoding) |
| out_valid | output | 1 | Packed result present |
| out_word | output | 32 | Single-precision word |
| out_unf | output | 1 | Underflow flag |
| out_ovf | output | 1 | Overflow flag |
| out_inexact | output | 1 | Inexact flag |
| out_operr | output | 1 | Operand-error flag |

## Verification
The bench builds the packer with its defaults, MW=32 and EW=10. This leaves eight bits below the fraction field, so guard, round and sticky each get distinct patterns, including exact ties under nearest-even. A 10-bit exponent reaches overflow far above 255 and also deficits larger than the whole mantissa, where every bit drains into sticky. Directed values cover the carry into 2.0, promotion from subnormal to normal and every mode/sign overflow pair. Randomised values then sweep the same ranges against a reference model that works from integer quotient and remainder.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int FRAC_W  = 23;
  localparam int BIAS    = 127;
  localparam int EXP_TOP = 255;

  typedef enum logic [1:0] {CLS_ZERO = 2'd0, CLS_NUM = 2'd1, CLS_INF = 2'd2, CLS_NAN = 2'd3} cls_e;
  typedef enum logic [1:0] {RM_NEAR = 2'd0, RM_ZERO = 2'd1, RM_DOWN = 2'd2, RM_UP = 2'd3} rmode_e;

  // increment decision for the kept mantissa
  function automatic logic round_up(input logic [1:0] mode, input logic sign,
                                    input logic lsb, input logic g, input logic r, input logic s);
    logic lost;
    lost = g | r | s;
    case (mode)
      RM_NEAR: round_up = g & (r | s | lsb);
      RM_ZERO: round_up = 1'b0;
      RM_DOWN: round_up = lost & sign;
      default: round_up = lost & ~sign;
    endcase
  endfunction

  // overflow goes to infinity (1) or to the largest finite value (0)
  function automatic logic ovf_to_inf(input logic [1:0] mode, input logic sign);
    case (mode)
      RM_NEAR: ovf_to_inf = 1'b1;
      RM_ZERO: ovf_to_inf = 1'b0;
      RM_DOWN: ovf_to_inf = sign;
      default: ovf_to_inf = ~sign;
    endcase
  endfunction
endpackage

// File: rtl/spk_align.sv
module spk_align #(
  parameter int MW = 32,
  parameter int EW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_num,
  input  logic signed [EW-1:0] exp_in,
  input  logic [MW-1:0]        mant_in,
  input  logic                 sticky_in,
  output logic signed [EW+1:0] biased,
  output logic                 is_sub,
  output logic [23:0]          kept,
  output logic                 g_bit,
  output logic                 r_bit,
  output logic                 s_bit
);
  localparam int BW  = EW + 2;
  localparam int SHW = $clog2(MW + 1);

  logic signed [BW-1:0] deficit;
  logic [SHW-1:0]       dcl;
  logic [MW-1:0]        shifted;
  logic                 lost;

  always_comb begin
    biased  = $signed({{2{exp_in[EW-1]}}, exp_in}) + $signed(BW'(spk_pkg::BIAS));
    is_sub  = (biased <= 0);
    deficit = $signed(BW'(1)) - biased;
    if (!is_sub)                          dcl = '0;
    else if (deficit > $signed(BW'(MW)))  dcl = SHW'(MW);
    else                                  dcl = deficit[SHW-1:0];
    shifted = mant_in >> dcl;
    lost    = |(mant_in & ~({MW{1'b1}} << dcl));
    kept    = shifted[MW-1 -: 24];
    g_bit   = shifted[MW-25];
    r_bit   = shifted[MW-26];
    s_bit   = (|shifted[MW-27:0]) | lost | sticky_in;
  end

  // R10: a normal number keeps its hidden bit in the top kept position
  a_r10_hidden_set: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_num && !is_sub) |-> kept[23]);
endmodule

// File: rtl/spk_round.sv
module spk_round (
  input  logic [23:0] kept,
  input  logic        g_bit,
  input  logic        r_bit,
  input  logic        s_bit,
  input  logic [1:0]  mode,
  input  logic        sign,
  output logic [24:0] rounded,
  output logic        inexact,
  output logic        bumped
);
  always_comb begin
    inexact = g_bit | r_bit | s_bit;
    bumped  = spk_pkg::round_up(mode, sign, kept[0], g_bit, r_bit, s_bit);
    rounded = {1'b0, kept} + {24'd0, bumped};
  end
endmodule

// File: rtl/sp_packer.sv
module sp_packer #(
  parameter int MW = 32,
  parameter int EW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_class,
  input  logic                 in_sign,
  input  logic signed [EW-1:0] in_exp,
  input  logic [MW-1:0]        in_mant,
  input  logic                 in_sticky,
  input  logic [1:0]           in_rmode,
  output logic                 out_valid,
  output logic [31:0]          out_word,
  output logic                 out_unf,
  output logic                 out_ovf,
  output logic                 out_inexact,
  output logic                 out_operr
);
  import spk_pkg::*;
  localparam int BW = EW + 2;

  logic signed [BW-1:0] biased, fexp;
  logic                 is_sub, g_bit, r_bit, s_bit, inexact, bumped;
  logic [23:0]          kept;
  logic [24:0]          rounded;
  logic                 ev_num, ev_promote, ev_carry2, ev_ovf;
  logic [31:0]          nxt_word;
  logic                 nxt_unf, nxt_ovf, nxt_inx, nxt_opr;

  assign ev_num = (in_class == CLS_NUM);

  spk_align #(.MW(MW), .EW(EW)) u_align (
    .clk(clk), .rst_n(rst_n), .chk_num(in_valid && ev_num),
    .exp_in(in_exp), .mant_in(in_mant), .sticky_in(in_sticky),
    .biased(biased), .is_sub(is_sub), .kept(kept),
    .g_bit(g_bit), .r_bit(r_bit), .s_bit(s_bit));

  spk_round u_round (
    .kept(kept), .g_bit(g_bit), .r_bit(r_bit), .s_bit(s_bit),
    .mode(in_rmode), .sign(in_sign),
    .rounded(rounded), .inexact(inexact), .bumped(bumped));

  always_comb begin
    ev_promote = is_sub && rounded[23];
    ev_carry2  = !is_sub && rounded[24];
    if (is_sub) fexp = ev_promote ? $signed(BW'(1)) : '0;
    else        fexp = biased + $signed({{(BW-1){1'b0}}, rounded[24]});
    ev_ovf = ev_num && (fexp >= $signed(BW'(EXP_TOP)));

    nxt_unf = 1'b0;
    nxt_ovf = 1'b0;
    nxt_inx = 1'b0;
    nxt_opr = 1'b0;
    case (in_class)
      CLS_ZERO: nxt_word = {in_sign, 31'd0};
      CLS_INF:  nxt_word = {in_sign, 8'hFF, 23'd0};
      CLS_NAN:  nxt_word = {in_sign, 8'hFF, in_mant[MW-2 -: FRAC_W]};
      default: begin
        nxt_unf = is_sub;
        nxt_inx = inexact | ev_ovf;
        nxt_ovf = ev_ovf;
        nxt_opr = ev_ovf;
        if (ev_ovf)
          nxt_word = ovf_to_inf(in_rmode, in_sign) ? {in_sign, 8'hFF, 23'd0}
                                                   : {in_sign, 8'hFE, 23'h7FFFFF};
        else
          nxt_word = {in_sign, fexp[7:0], rounded[22:0]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_unf     <= 1'b0;
      out_ovf     <= 1'b0;
      out_inexact <= 1'b0;
      out_operr   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word    <= nxt_word;
        out_unf     <= nxt_unf;
        out_ovf     <= nxt_ovf;
        out_inexact <= nxt_inx;
        out_operr   <= nxt_opr;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_ovf_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_inexact && out_operr));
  a_r9_ovf_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_word[30:23] >= 8'd254));
  a_r6_sub_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> (out_word[30:23] <= 8'd1));
  a_r5_carry_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_carry2 && !ev_ovf) |=> (out_word[22:0] == 23'd0));
  a_r7_promote: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_num && ev_promote) |=> (out_word[30:0] == {8'd1, 23'd0}));
endmodule

// File: tb/sim_sp_packer.sv
`timescale 1ns/1ps
module sim_sp_packer;
  localparam int MW = 32;
  localparam int EW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_class = '0;
  logic in_sign = 1'b0;
  logic signed [EW-1:0] in_exp = '0;
  logic [MW-1:0] in_mant = '0;
  logic in_sticky = 1'b0;
  logic [1:0] in_rmode = '0;
  logic out_valid, out_unf, out_ovf, out_inexact, out_operr;
  logic [31:0] out_word;

  int errors = 0;
  int checks = 0;
  logic armed = 1'b0;

  always #5 clk = ~clk;

  sp_packer #(.MW(MW), .EW(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_word(out_word),
    .out_unf(out_unf), .out_ovf(out_ovf), .out_inexact(out_inexact), .out_operr(out_operr));

  // expected outputs: {unf, ovf, inexact, operr, word}
  logic        exp_valid = 1'b0;
  logic [35:0] exp_res = '0;
  string       exp_tag = "R1";

  task automatic ref_model(input logic [1:0] cls, input logic sg, input int e,
                           input logic [MW-1:0] m, input logic st, input logic [1:0] md,
                           output logic [35:0] res, output string tag);
    longint unsigned mm, q, rem, half;
    int biased, k, ef;
    logic inx, inc, big;
    logic [22:0] frac;
    res = '0;
    if (cls == 2'd0) begin res[31:0] = {sg, 31'd0}; tag = "R2"; return; end
    if (cls == 2'd2) begin res[31:0] = {sg, 8'hFF, 23'd0}; tag = "R2"; return; end
    if (cls == 2'd3) begin res[31:0] = {sg, 8'hFF, m[MW-2 -: 23]}; tag = "R3"; return; end
    biased = e + 127;
    mm = (longint'(m) << 1) | longint'(st);
    k = MW - 24 + ((biased <= 0) ? (1 - biased) : 0);
    big = (k + 1 >= 60);
    if (big) begin q = 0; rem = mm; half = 0; end
    else begin
      q = mm >> (k + 1);
      rem = mm - (q << (k + 1));
      half = longint'(1) << k;
    end
    inx = (rem != 0);
    case (md)
      2'd0: inc = big ? 1'b0 : ((rem > half) || (rem == half && q[0]));
      2'd1: inc = 1'b0;
      2'd2: inc = inx && sg;
      default: inc = inx && !sg;
    endcase
    q = q + longint'(inc);
    tag = inx ? "R4" : "R10";
    if (biased <= 0) begin
      ef = (q >= 64'h800000) ? 1 : 0;
      frac = q[22:0];
      tag = (ef == 1) ? "R7" : "R6";
    end else if (q >= 64'h1000000) begin
      ef = biased + 1;
      frac = q[23:1];
      tag = "R5";
    end else begin
      ef = biased;
      frac = q[22:0];
    end
    res[35] = (biased <= 0);
    res[33] = inx;
    if (ef >= 255) begin
      res[34] = 1'b1; res[33] = 1'b1; res[32] = 1'b1;
      tag = "R9";
      if (md == 2'd0 || (md == 2'd3 && !sg) || (md == 2'd2 && sg))
        res[31:0] = {sg, 8'hFF, 23'd0};
      else
        res[31:0] = {sg, 8'hFE, 23'h7FFFFF};
    end else
      res[31:0] = {sg, ef[7:0], frac};
  endtask

  // reference follows the inputs at every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_res <= '0;
      exp_tag <= "R1";
    end else begin
      logic [35:0] r;
      string t;
      exp_valid <= in_valid;
      if (in_valid) begin
        ref_model(in_class, in_sign, int'(in_exp), in_mant, in_sticky, in_rmode, r, t);
        exp_res <= r;
        exp_tag <= t;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (out_valid !== exp_valid) begin
        errors++;
        $display("FAIL R1 valid: actual=%0b expected=%0b", out_valid, exp_valid);
      end
      if (exp_valid) begin
        checks++;
        if ({out_unf, out_ovf, out_inexact, out_operr, out_word} !== exp_res) begin
          errors++;
          $display("FAIL %s: actual=%09h expected=%09h (flags unf,ovf,inx,opr then word)",
                   exp_tag, {out_unf, out_ovf, out_inexact, out_operr, out_word}, exp_res);
        end
      end
    end
  end

  task automatic drive(input logic [1:0] c, input logic sg, input int e,
                       input logic [MW-1:0] m, input logic st, input logic [1:0] md);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_sign = sg; in_exp = EW'(e);
    in_mant = m; in_sticky = st; in_rmode = md;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if ({out_valid, out_unf, out_ovf, out_inexact, out_operr, out_word} !== 37'd0) begin
      errors++;
      $display("FAIL R1 reset: actual=%0h expected=0",
               {out_valid, out_unf, out_ovf, out_inexact, out_operr, out_word});
    end
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1'b1;
    // R10 exact normals
    drive(2'd1, 1'b0, 0, 32'h80000000, 1'b0, 2'd0);
    drive(2'd1, 1'b1, -3, 32'hA5A5A500, 1'b0, 2'd1);
    // R2 zero and infinity, R3 NaN
    drive(2'd0, 1'b1, 5, 32'h0, 1'b0, 2'd0);
    drive(2'd2, 1'b0, 0, 32'h0, 1'b0, 2'd3);
    drive(2'd3, 1'b1, 0, 32'hC0001234, 1'b1, 2'd0);
    idle();
    // R4 ties under nearest-even, and each mode with a lone sticky
    drive(2'd1, 1'b0, 0, 32'h80000080, 1'b0, 2'd0);
    drive(2'd1, 1'b0, 0, 32'h80000180, 1'b0, 2'd0);
    drive(2'd1, 1'b0, 0, 32'h80000080, 1'b1, 2'd0);
    for (int md = 0; md < 4; md++) begin
      drive(2'd1, 1'b0, 1, 32'h80000000, 1'b1, md[1:0]);
      drive(2'd1, 1'b1, 1, 32'h80000000, 1'b1, md[1:0]);
    end
    // R5 carry to 2.0
    drive(2'd1, 1'b0, 0, 32'hFFFFFFFF, 1'b0, 2'd0);
    // R6 subnormals, including a deficit beyond the mantissa
    drive(2'd1, 1'b0, -127, 32'h80000000, 1'b0, 2'd0);
    drive(2'd1, 1'b0, -149, 32'h80000000, 1'b0, 2'd0);
    drive(2'd1, 1'b0, -400, 32'h80000000, 1'b0, 2'd3);
    drive(2'd1, 1'b1, -400, 32'h80000000, 1'b0, 2'd3);
    // R7 promotion to smallest normal
    drive(2'd1, 1'b0, -127, 32'hFFFFFFFF, 1'b0, 2'd0);
    idle();
    // R8/R9 overflow, each mode and sign, plus rounding into overflow
    for (int md = 0; md < 4; md++) begin
      drive(2'd1, 1'b0, 128, 32'h80000000, 1'b0, md[1:0]);
      drive(2'd1, 1'b1, 300, 32'h80000000, 1'b0, md[1:0]);
    end
    drive(2'd1, 1'b0, 127, 32'hFFFFFFFF, 1'b0, 2'd0);
    drive(2'd1, 1'b0, 127, 32'hFFFFFFFF, 1'b0, 2'd1);
    idle();
    // randomised sweep
    for (int i = 0; i < 4000; i++) begin
      int e;
      logic [1:0] c;
      c = ($urandom_range(0, 9) < 8) ? 2'd1 : 2'($urandom_range(0, 3));
      e = $urandom_range(0, 360) - 190;
      if ($urandom_range(0, 7) == 0) idle();
      drive(c, 1'($urandom), e, {1'b1, 31'($urandom)}, 1'($urandom), 2'($urandom));
    end
    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule